// File: doc/BRIEF.md
# Dual-Clock Queue with Explicit Reads

This block is a first-in first-out queue for 9-bit words. It sits between two unrelated clock domains. The producer side writes on its own clock. An active-low enable requests each write, and an active-low flag reports that no room is left. The consumer side reads on a second clock. Its output is a registered word that changes only when an active-low read enable asks for the next entry. An active-low flag reports that nothing is stored.

There is no fall-through. A word written into an empty queue stays inside until two things have happened: the empty indication has cleared, and a read has been requested. When no read is accepted, the output register keeps the last word it loaded. The read data can be released to high impedance through an active-low output enable. A separate valid line reports when the data lines are driven.

Both flags are registered. Each flag is asserted on the same edge as the access that fills or drains the queue. After an access in the opposite domain, each flag clears on the second edge of its own clock. The depth is a parameterised power of two.

Top module: `dcq_fifo`

## Requirements
- R1: Words leave the output register in the order they were accepted, and no word is lost, repeated or invented.
- R2: A rising write-clock edge stores the input word only when `wr_en_n` is 0 and `full_n` is 1. Write requests made while `full_n` is 0 have no effect, so a full queue still holds exactly DEPTH words.
- R3: A rising read-clock edge loads the next stored word into the output register only when `rd_en_n` is 0 and `empty_n` is 1. On any other read edge, including a requested read while empty, the output register holds its value.
- R4: A word written into an empty queue does not appear on `rd_data` by itself. The output keeps its earlier value after `empty_n` has risen, and changes only on an accepted read.
- R5: The read edge that takes out the last stored word also drives `empty_n` to 0, and `rd_data` keeps showing that word afterwards.
- R6: The write edge that stores the DEPTH-th held word also drives `full_n` to 0.
- R7: After a write into an empty queue, `empty_n` becomes 1 no later than the second rising read-clock edge after the writing edge.
- R8: After a read from a full queue, `full_n` becomes 1 no later than the second rising write-clock edge after the reading edge.
- R9: While `oe_n` is 1, `rd_vld` is 0 and every bit of `rd_data` is high impedance. While `oe_n` is 0, `rd_vld` is 1 and `rd_data` shows the output register.
- R10: While `rst` is 1, `empty_n` is 0, `full_n` is 1, and the output register holds 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Asynchronous reset, active high, for both domains |
| wr_clk | input | 1 | Producer clock |
| wr_en_n | input | 1 | Write request, active low |
| wr_data | input | 9 | Word to store |
| full_n | output | 1 | 0 when no room is left |
| rd_clk | input | 1 | Consumer clock |
| rd_en_n | input | 1 | Read request, active low |
| oe_n | input | 1 | Output drive enable, active low |
| rd_data | output | 9 | Output register, or high impedance while disabled |
| rd_vld | output | 1 | 1 while `rd_data` is driven |
| empty_n | output | 1 | 0 when nothing is stored |

## Verification
The two clocks run at unrelated periods and with a seeded random phase. A single word written into an empty queue shows that the first word is held back, and it measures how many read edges the empty flag takes to clear. A fill past DEPTH with reads stopped tells apart a queue that drops excess writes from one that overwrites them. A single read from the full queue then measures the release delay of the full flag. Two random phases, one mostly writing and one mostly reading, keep the queue near each flag in turn. They check ordering against a scoreboard, holding on refused reads, and the flag that must fall on the final read.

// File: rtl/dcq_pkg.sv
`timescale 1ns/1ps
package dcq_pkg;

    localparam int unsigned DCQ_DATA_W = 9;
    localparam int unsigned DCQ_ADDR_W = 4;

    // reflected binary code of a counter value
    function automatic logic [31:0] gray_of(input logic [31:0] bin);
        return bin ^ (bin >> 1);
    endfunction

endpackage

// File: rtl/dcq_sync.sv
`timescale 1ns/1ps
module dcq_sync #(
    parameter int unsigned W      = 5,
    parameter int unsigned STAGES = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_comb stage_d[i] = din;
        end else begin : g_next
            always_comb stage_d[i] = stage_q[i-1];
        end

        always_ff @(posedge clk or posedge rst) begin
            if (rst) stage_q[i] <= '0;
            else     stage_q[i] <= stage_d[i];
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/dcq_ram.sv
`timescale 1ns/1ps
module dcq_ram #(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 9,
    localparam int unsigned DEPTH = 1 << AW
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    // the consumer's output register is the only read stage
    assign rdata = mem_q[raddr];

endmodule

// File: rtl/dcq_wr_ctrl.sv
`timescale 1ns/1ps
module dcq_wr_ctrl
    import dcq_pkg::*;
#(
    parameter int unsigned AW = 4,
    localparam int unsigned PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en_n,
    input  logic [PW-1:0] rd_gray_s,
    output logic          wr_fire,
    output logic [PW-1:0] wr_bin,
    output logic [PW-1:0] wr_gray,
    output logic          full_n
);

    // two top bits flipped: write pointer one lap ahead of read pointer
    localparam logic [PW-1:0] LAP_MASK = PW'(3) << (PW - 2);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          full;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic [PW-1:0] lap_ptr;

    always_comb begin
        st_d    = st_q;
        wr_fire = !wr_en_n && !st_q.full;
        if (wr_fire) st_d.bin = st_q.bin + PW'(1);
        st_d.gray = PW'(gray_of(32'(st_d.bin)));
        lap_ptr   = rd_gray_s ^ LAP_MASK;
        st_d.full = (st_d.gray == lap_ptr);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '{bin: '0, gray: '0, full: 1'b0};
        else     st_q <= st_d;
    end

    assign wr_bin  = st_q.bin;
    assign wr_gray = st_q.gray;
    assign full_n  = !st_q.full;

endmodule

// File: rtl/dcq_rd_ctrl.sv
`timescale 1ns/1ps
module dcq_rd_ctrl
    import dcq_pkg::*;
#(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 9,
    localparam int unsigned PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en_n,
    input  logic [PW-1:0] wr_gray_s,
    input  logic [DW-1:0] mem_rdata,
    output logic [PW-1:0] rd_bin,
    output logic [PW-1:0] rd_gray,
    output logic          empty_n,
    output logic [DW-1:0] rd_word
);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          empty;
        logic [DW-1:0] word;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic      rd_fire;

    always_comb begin
        st_d    = st_q;
        rd_fire = !rd_en_n && !st_q.empty;
        if (rd_fire) begin
            st_d.bin  = st_q.bin + PW'(1);
            st_d.word = mem_rdata;
        end
        st_d.gray  = PW'(gray_of(32'(st_d.bin)));
        st_d.empty = (st_d.gray == wr_gray_s);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '{bin: '0, gray: '0, empty: 1'b1, word: '0};
        else     st_q <= st_d;
    end

    assign rd_bin  = st_q.bin;
    assign rd_gray = st_q.gray;
    assign empty_n = !st_q.empty;
    assign rd_word = st_q.word;

endmodule

// File: rtl/dcq_fifo.sv
`timescale 1ns/1ps
module dcq_fifo
    import dcq_pkg::*;
#(
    parameter int unsigned AW          = DCQ_ADDR_W,
    parameter int unsigned DW          = DCQ_DATA_W,
    parameter int unsigned SYNC_STAGES = 1,
    localparam int unsigned PW = AW + 1
) (
    input  logic          rst,
    input  logic          wr_clk,
    input  logic          wr_en_n,
    input  logic [DW-1:0] wr_data,
    output logic          full_n,
    input  logic          rd_clk,
    input  logic          rd_en_n,
    input  logic          oe_n,
    output logic [DW-1:0] rd_data,
    output logic          rd_vld,
    output logic          empty_n
);

    logic          wr_fire;
    logic [PW-1:0] wr_bin, wr_gray, wr_gray_s;
    logic [PW-1:0] rd_bin, rd_gray, rd_gray_s;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] rd_word;

    dcq_wr_ctrl #(.AW(AW)) i_wr_ctrl (
        .clk      (wr_clk),
        .rst      (rst),
        .wr_en_n  (wr_en_n),
        .rd_gray_s(rd_gray_s),
        .wr_fire  (wr_fire),
        .wr_bin   (wr_bin),
        .wr_gray  (wr_gray),
        .full_n   (full_n)
    );

    dcq_sync #(.W(PW), .STAGES(SYNC_STAGES)) i_sync_rd2wr (
        .clk (wr_clk),
        .rst (rst),
        .din (rd_gray),
        .dout(rd_gray_s)
    );

    dcq_sync #(.W(PW), .STAGES(SYNC_STAGES)) i_sync_wr2rd (
        .clk (rd_clk),
        .rst (rst),
        .din (wr_gray),
        .dout(wr_gray_s)
    );

    dcq_ram #(.AW(AW), .DW(DW)) i_ram (
        .wr_clk(wr_clk),
        .we    (wr_fire),
        .waddr (wr_bin[AW-1:0]),
        .wdata (wr_data),
        .raddr (rd_bin[AW-1:0]),
        .rdata (mem_rdata)
    );

    dcq_rd_ctrl #(.AW(AW), .DW(DW)) i_rd_ctrl (
        .clk      (rd_clk),
        .rst      (rst),
        .rd_en_n  (rd_en_n),
        .wr_gray_s(wr_gray_s),
        .mem_rdata(mem_rdata),
        .rd_bin   (rd_bin),
        .rd_gray  (rd_gray),
        .empty_n  (empty_n),
        .rd_word  (rd_word)
    );

    assign rd_vld  = !oe_n;
    assign rd_data = oe_n ? {DW{1'bz}} : rd_word;

endmodule

// File: rtl/dcq_fifo_chk.sv
`timescale 1ns/1ps
module dcq_fifo_chk #(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 9,
    localparam int unsigned PW = AW + 1,
    localparam int unsigned DEPTH = 1 << AW
) (
    input logic          rst,
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rd_en_n,
    input logic          full_n,
    input logic          empty_n,
    input logic [PW-1:0] wr_bin,
    input logic [PW-1:0] rd_bin,
    input logic [DW-1:0] rd_word
);

    AST_FULL_BLOCKS_WR: assert property (@(posedge wr_clk) disable iff (rst)
        !full_n |=> $stable(wr_bin)); // R2

    AST_EMPTY_BLOCKS_RD: assert property (@(posedge rd_clk) disable iff (rst)
        !empty_n |=> ($stable(rd_bin) && $stable(rd_word))); // R3

    AST_HOLD_NO_READ: assert property (@(posedge rd_clk) disable iff (rst)
        rd_en_n |=> $stable(rd_word)); // R3

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (rst)
        (PW'(wr_bin - rd_bin) <= PW'(DEPTH))); // R6

    AST_NO_UNDERRUN: assert property (@(posedge rd_clk) disable iff (rst)
        (PW'(wr_bin - rd_bin) <= PW'(DEPTH))); // R5

    always @(posedge rd_clk) begin
        if (rst) begin
            AST_RST_EMPTY: assert (!empty_n && rd_word == '0); // R10
        end
    end

    always @(posedge wr_clk) begin
        if (rst) begin
            AST_RST_FULL: assert (full_n); // R10
        end
    end

endmodule

bind dcq_fifo dcq_fifo_chk #(.AW(AW), .DW(DW)) i_dcq_fifo_chk (
    .rst    (rst),
    .wr_clk (wr_clk),
    .rd_clk (rd_clk),
    .rd_en_n(rd_en_n),
    .full_n (full_n),
    .empty_n(empty_n),
    .wr_bin (wr_bin),
    .rd_bin (rd_bin),
    .rd_word(rd_word)
);

// File: tb/test_dcq_fifo.sv
`timescale 1ns/1ps
module test_dcq_fifo;

    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic       rst = 1'b0;
    logic       wr_clk = 1'b0;
    logic       rd_clk = 1'b0;
    logic       wr_en_n = 1'b1;
    logic [8:0] wr_data = '0;
    logic       rd_en_n = 1'b1;
    logic       oe_n = 1'b0;
    logic       full_n, empty_n, rd_vld;
    logic [8:0] rd_data;

    int n_chk = 0, n_bad = 0;
    int n_wr = 0, n_rd = 0;
    int wr_edges = 0, rd_edges = 0;
    int rd_snap = 0, wr_snap = 0;
    logic [8:0] sbq[$];

    dcq_fifo #(.AW(AW)) i_dcq_fifo (
        .rst(rst), .wr_clk(wr_clk), .wr_en_n(wr_en_n), .wr_data(wr_data),
        .full_n(full_n), .rd_clk(rd_clk), .rd_en_n(rd_en_n), .oe_n(oe_n),
        .rd_data(rd_data), .rd_vld(rd_vld), .empty_n(empty_n)
    );

    // 100 MHz producer clock
    initial forever #5 wr_clk = ~wr_clk;

    // consumer clock: unrelated period, seeded phase on a 10 ps grid offset by 5 ps
    initial begin
        real ph;
        ph = 0.005 + 0.01 * real'($urandom(32'h5eed) % 700);
        #(ph);
        forever #6.85 rd_clk = ~rd_clk;
    end

    always @(posedge wr_clk) wr_edges++;
    always @(posedge rd_clk) rd_edges++;

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete: actual timeout expected finish");
        summary();
        $finish;
    end

    task automatic wr_align();
        @(posedge wr_clk);
        #1;
    endtask

    task automatic rd_align();
        @(posedge rd_clk);
        #1;
    endtask

    task automatic wr_step(input bit en, input logic [8:0] d);
        bit acc;
        wr_en_n = !en;
        wr_data = d;
        acc = en && full_n;
        @(posedge wr_clk);
        if (acc) rd_snap = rd_edges;
        #1;
        if (acc) begin
            sbq.push_back(d);
            n_wr++;
            if (n_wr - n_rd == DEPTH)
                chk(full_n == 1'b0, "R6", "full_n after filling write", full_n, 0);
        end
    endtask

    task automatic rd_step(input bit en);
        bit acc;
        logic [8:0] prev, e;
        rd_en_n = !en;
        acc  = en && empty_n;
        prev = rd_data;
        @(posedge rd_clk);
        wr_snap = wr_edges;
        #1;
        if (acc) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R1", "read accepted with nothing stored", rd_data, 0);
            end else begin
                e = sbq.pop_front();
                n_rd++;
                chk(rd_data == e, "R1", "read word order", rd_data, e);
                if (sbq.size() == 0)
                    chk(empty_n == 1'b0 && rd_data == e, "R5",
                        "empty_n after last read", empty_n, 0);
            end
        end else begin
            chk(rd_data == prev, "R3", "output held without accepted read", rd_data, prev);
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 4 * DEPTH + 8 && (sbq.size() != 0 || empty_n); i++)
            rd_step(1'b1);
        rd_en_n = 1'b1;
    endtask

    task automatic random_phase(input int n_steps, input int wr_pct, input int rd_pct);
        fork
            begin
                for (int i = 0; i < n_steps; i++)
                    wr_step(($urandom % 100) < wr_pct, 9'($urandom));
                wr_en_n = 1'b1;
            end
            begin
                for (int i = 0; i < n_steps; i++)
                    rd_step(($urandom % 100) < rd_pct);
                rd_en_n = 1'b1;
            end
        join
    endtask

    initial begin
        int lat;
        int start_rd;
        #1 rst = 1'b1;
        #19;
        // R10: reset state
        chk(empty_n == 1'b0, "R10", "empty_n in reset", empty_n, 0);
        chk(full_n == 1'b1, "R10", "full_n in reset", full_n, 1);
        chk(rd_data == 9'h000, "R10", "output register in reset", rd_data, 0);
        chk(rd_vld == 1'b1, "R9", "rd_vld with oe_n low", rd_vld, 1);
        #27.5 rst = 1'b0;

        // R7 / R4: single word into empty queue
        wr_align();
        wr_step(1'b1, 9'h1A5);
        wr_en_n = 1'b1;
        for (int i = 0; i < 6 && !empty_n; i++) rd_align();
        lat = rd_edges - rd_snap;
        chk(empty_n == 1'b1, "R7", "empty_n cleared", empty_n, 1);
        chk(lat >= 1 && lat <= 2, "R7", "read edges until empty_n rises", lat, 2);
        chk(rd_data == 9'h000, "R4", "word not presented before read", rd_data, 0);
        rd_step(1'b0);
        chk(rd_data == 9'h000, "R4", "still held after idle edge", rd_data, 0);
        rd_step(1'b1);
        rd_step(1'b1);   // requested while empty: must hold (R3)
        rd_en_n = 1'b1;
        chk(rd_data == 9'h1A5, "R5", "last word kept after empty", rd_data, 9'h1A5);

        // R9: output disable
        oe_n = 1'b1;
        #3;
        chk(rd_vld == 1'b0, "R9", "rd_vld with oe_n high", rd_vld, 0);
        chk(rd_data === 9'bzzzzzzzzz, "R9", "rd_data high impedance", rd_data, 9'h1ff);
        oe_n = 1'b0;
        #3;
        chk(rd_data == 9'h1A5, "R9", "rd_data driven again", rd_data, 9'h1A5);

        // R2 / R6: fill past capacity with reads stopped
        wr_align();
        for (int i = 0; i < DEPTH + 3; i++) wr_step(1'b1, 9'(9'h040 + i));
        wr_en_n = 1'b1;
        chk(full_n == 1'b0, "R6", "full_n after fill", full_n, 0);
        chk(sbq.size() == DEPTH, "R2", "words accepted while filling", sbq.size(), DEPTH);

        // R8: one read from full queue
        start_rd = n_rd;
        rd_align();
        rd_step(1'b1);
        rd_en_n = 1'b1;
        for (int i = 0; i < 6 && !full_n; i++) wr_align();
        lat = wr_edges - wr_snap;
        chk(full_n == 1'b1, "R8", "full_n cleared", full_n, 1);
        chk(lat >= 1 && lat <= 2, "R8", "write edges until full_n rises", lat, 2);
        rd_align();
        drain();
        chk(n_rd - start_rd == DEPTH, "R2", "words read back after overfill",
            n_rd - start_rd, DEPTH);
        chk(empty_n == 1'b0, "R5", "empty after drain", empty_n, 0);

        // R1: random traffic, write-heavy then read-heavy
        wr_align();
        random_phase(1500, 80, 35);
        repeat (4) rd_align();
        drain();
        chk(sbq.size() == 0, "R1", "words left after write-heavy phase", sbq.size(), 0);
        wr_align();
        random_phase(1500, 35, 85);
        repeat (4) rd_align();
        drain();
        chk(sbq.size() == 0, "R1", "words left after read-heavy phase", sbq.size(), 0);
        chk(n_wr == n_rd, "R1", "written versus read totals", n_rd, n_wr);

        summary();
        $finish;
    end

endmodule